// File: doc/BRIEF.md
# Bus break condition monitor

The monitor observes every transfer on a shared system bus that a CPU and two DMA engines drive. Two independent break channels compare each transfer against a programmed physical address, an ignore mask, and selects for transfer kind (instruction fetch or data), direction and access size. When a transfer satisfies a channel, that channel's sticky match flag is set. A one-cycle break request is sent to the CPU on the following clock, unless the CPU's block input is high.

The kind of each transfer depends on where it came from. A transfer counts as an instruction fetch only when the CPU issued it and it was caused by a fetch; this includes line fills that a fetch triggers. Everything else is data, and DMA transfers are always data, even if their fetch-origin bit is set. The monitor compares the address exactly as it appears on the bus. Fetches and line fills arrive as longwords aligned down to a 4-byte boundary. Uncached data and write-through write misses keep their own size and byte address. Software programs the channels and reads or clears the flags through a small synchronous register port.

Top module: `bus_break_monitor`

## Requirements
- R1: A transfer is evaluated only in a cycle where `bus_valid` is 1, whichever master issued it (00 CPU, 01 DMA engine 0, 10 DMA engine 1). With `bus_valid` at 0 no flag changes and no request is produced.
- R2: A channel's address condition holds when `((bus_addr ^ brk_addr) & ~mask) == 0`. A mask bit of 1 ignores that address bit. The bus address is used as-is, with no rounding.
- R3: A transfer is a fetch only when `bus_master` is 00 (CPU) and `bus_fetch` is 1. All other transfers are data, including DMA transfers with `bus_fetch` set.
- R4: The kind select is control bits [2:1]: 01 matches fetch only, 10 matches data only, 00 and 11 match either.
- R5: The direction select is control bits [4:3]: 01 matches reads only, 10 matches writes only, 00 and 11 match either. The size select is control bits [6:5]: 00 matches any size, 01 byte, 10 word, 11 longword. `bus_size` is coded 00 byte, 01 word, 10 longword.
- R6: Control bit [0] enables a channel. A channel with enable at 0 never matches.
- R7: Match flags are read at register 3, bit 0 for channel A and bit 1 for channel B. They are sticky. Writing 0 to a bit clears it, and writing 1 leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R8: `brk_req` is high for exactly the one clock after a cycle in which at least one channel matched. Otherwise it is 0.
- R9: While `cpu_block` is 1 during a matching cycle, no request is produced, but the matching channels' flags are still set.
- R10: When both channels match the same transfer, both flags are set and a single one-cycle request is produced.
- R11: Register map: A address 0, A mask 1, A control 2, flags 3, B address 4, B mask 5, B control 6, and register 7 reads 0. Control registers read back bits [6:0]. All registers and `brk_req` reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Transfer present this cycle |
| bus_addr | input | 32 | Physical transfer address |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 00 byte, 01 word, 10 longword |
| bus_master | input | 2 | 00 CPU, 01 DMA 0, 10 DMA 1 |
| bus_fetch | input | 1 | Transfer caused by an instruction fetch |
| cpu_block | input | 1 | CPU block bit, suppresses requests |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| brk_req | output | 1 | One-cycle break request |

## Verification
Transfers are driven from all three masters with the fetch-origin bit both set and clear. This separates classification by origin from classification by master ID alone. Address tests use exact hits, single-bit misses, masked low bits, and an aligned fetch address against an unaligned break address. Together these show that the masking is correct and that the monitor does no rounding of its own. Direction, size and kind selects are each tried against a matching and a non-matching transfer. The block bit, double matches, idle cycles, and a clearing write in the same cycle as a match show how request generation and flag updates differ.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    localparam int BBM_AW     = 32;
    localparam int CTRL_W     = 7;
    localparam int CTRL_EN    = 0;
    localparam int CTRL_KIND  = 1;
    localparam int CTRL_DIR   = 3;
    localparam int CTRL_SIZE  = 5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } bus_size_e;

    typedef enum logic [1:0] {
        MST_CPU  = 2'b00,
        MST_DMA0 = 2'b01,
        MST_DMA1 = 2'b10,
        MST_RSVD = 2'b11
    } master_e;

    typedef enum logic {
        KIND_DATA  = 1'b0,
        KIND_FETCH = 1'b1
    } cyc_kind_e;

    typedef struct packed {
        logic              valid;
        logic [BBM_AW-1:0] addr;
        logic              write;
        bus_size_e         size;
        master_e           master;
        logic              fetch;
    } bus_cycle_t;

    typedef struct packed {
        logic              valid;
        logic [BBM_AW-1:0] addr;
        logic              write;
        bus_size_e         size;
        cyc_kind_e         kind;
    } cls_cycle_t;

    typedef struct packed {
        logic              enable;
        logic [1:0]        kind_sel;
        logic [1:0]        dir_sel;
        logic [1:0]        size_sel;
        logic [BBM_AW-1:0] addr;
        logic [BBM_AW-1:0] mask;
    } ch_cfg_t;

    function automatic logic kind_ok(input logic [1:0] sel, input cyc_kind_e kind);
        case (sel)
            2'b01:   return kind == KIND_FETCH;
            2'b10:   return kind == KIND_DATA;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic dir_ok(input logic [1:0] sel, input logic write);
        case (sel)
            2'b01:   return !write;
            2'b10:   return write;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic size_ok(input logic [1:0] sel, input bus_size_e size);
        if (sel == 2'b00) return 1'b1;
        return sel == (2'(size) + 2'd1);
    endfunction

    function automatic logic addr_ok(input logic [BBM_AW-1:0] a,
                                     input logic [BBM_AW-1:0] b,
                                     input logic [BBM_AW-1:0] mask);
        return ((a ^ b) & ~mask) == '0;
    endfunction

endpackage

// File: rtl/bbm_classify.sv
module bbm_classify
    import bbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_cycle_t cyc_i,
    output cls_cycle_t cls_o
);

    logic from_cpu_fetch;

    always_comb begin
        from_cpu_fetch = (cyc_i.master == MST_CPU) && cyc_i.fetch;
        cls_o.valid    = cyc_i.valid;
        cls_o.addr     = cyc_i.addr;
        cls_o.write    = cyc_i.write;
        cls_o.size     = cyc_i.size;
        cls_o.kind     = from_cpu_fetch ? KIND_FETCH : KIND_DATA;
    end

    // R3: transfers from a DMA engine are never classed as fetches
    a_r3_dma_is_data: assert property (@(posedge clk) disable iff (rst)
        (cyc_i.master != MST_CPU) |-> (cls_o.kind == KIND_DATA));

    // R3: a CPU transfer without fetch origin is data
    a_r3_cpu_data: assert property (@(posedge clk) disable iff (rst)
        (!cyc_i.fetch) |-> (cls_o.kind == KIND_DATA));

endmodule

// File: rtl/bbm_channel.sv
module bbm_channel
    import bbm_pkg::*;
(
    input  ch_cfg_t    cfg_i,
    input  cls_cycle_t cls_i,
    output logic       match_o
);

    logic hit_addr;
    logic hit_kind;
    logic hit_dir;
    logic hit_size;

    always_comb begin
        hit_addr = addr_ok(cls_i.addr, cfg_i.addr, cfg_i.mask);
        hit_kind = kind_ok(cfg_i.kind_sel, cls_i.kind);
        hit_dir  = dir_ok(cfg_i.dir_sel, cls_i.write);
        hit_size = size_ok(cfg_i.size_sel, cls_i.size);
        match_o  = cls_i.valid && cfg_i.enable &&
                   hit_addr && hit_kind && hit_dir && hit_size;
    end

endmodule

// File: rtl/bbm_regs.sv
module bbm_regs
    import bbm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int RA_W   = $clog2(NUM_CH) + 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_we,
    input  logic [RA_W-1:0]           reg_addr,
    input  logic [BBM_AW-1:0]         reg_wdata,
    output logic [BBM_AW-1:0]         reg_rdata,
    input  logic [NUM_CH-1:0]         match_i,
    output ch_cfg_t [NUM_CH-1:0]      cfg_o
);

    localparam int CH_W = RA_W - 2;
    localparam logic [RA_W-1:0] FLAG_IDX = RA_W'(3);

    logic [BBM_AW-1:0] addr_q [NUM_CH];
    logic [BBM_AW-1:0] mask_q [NUM_CH];
    logic [CTRL_W-1:0] ctrl_q [NUM_CH];
    logic [NUM_CH-1:0] flags_q;
    logic [NUM_CH-1:0] clr_mask;
    logic              flag_wr;

    assign flag_wr  = reg_we && (reg_addr == FLAG_IDX);
    assign clr_mask = flag_wr ? ~reg_wdata[NUM_CH-1:0] : '0;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [CH_W-1:0] CH_ID = CH_W'(c);
        logic sel_ch;
        assign sel_ch = reg_we && (reg_addr[RA_W-1:2] == CH_ID);

        always_ff @(posedge clk) begin
            if (rst) begin
                addr_q[c] <= '0;
                mask_q[c] <= '0;
                ctrl_q[c] <= '0;
            end else if (sel_ch) begin
                case (reg_addr[1:0])
                    2'd0:    addr_q[c] <= reg_wdata;
                    2'd1:    mask_q[c] <= reg_wdata;
                    2'd2:    ctrl_q[c] <= reg_wdata[CTRL_W-1:0];
                    default: ;
                endcase
            end
        end

        always_comb begin
            cfg_o[c].enable   = ctrl_q[c][CTRL_EN];
            cfg_o[c].kind_sel = ctrl_q[c][CTRL_KIND +: 2];
            cfg_o[c].dir_sel  = ctrl_q[c][CTRL_DIR +: 2];
            cfg_o[c].size_sel = ctrl_q[c][CTRL_SIZE +: 2];
            cfg_o[c].addr     = addr_q[c];
            cfg_o[c].mask     = mask_q[c];
        end

        // R7: a flag falls only after a write of 0 to its bit
        a_r7_clear_only_by_write: assert property (@(posedge clk) disable iff (rst)
            $fell(flags_q[c]) |-> $past(reg_we && (reg_addr == FLAG_IDX) && !reg_wdata[c]));

        // R7: a match always leaves the flag set, even against a clearing write
        a_r7_match_sets_flag: assert property (@(posedge clk) disable iff (rst)
            match_i[c] |=> flags_q[c]);

        // R6: a disabled channel reports no match
        a_r6_disabled_silent: assert property (@(posedge clk) disable iff (rst)
            !cfg_o[c].enable |-> !match_i[c]);
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_mask) | match_i;
    end

    always_comb begin
        logic [CH_W-1:0] rch;
        rch       = reg_addr[RA_W-1:2];
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rch == CH_W'(c)) begin
                case (reg_addr[1:0])
                    2'd0: reg_rdata = addr_q[c];
                    2'd1: reg_rdata = mask_q[c];
                    2'd2: reg_rdata = BBM_AW'(ctrl_q[c]);
                    default: reg_rdata = (c == 0) ? BBM_AW'(flags_q) : '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/bus_break_monitor.sv
module bus_break_monitor
    import bbm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int RA_W   = $clog2(NUM_CH) + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic [BBM_AW-1:0] bus_addr,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [1:0]        bus_master,
    input  logic              bus_fetch,
    input  logic              cpu_block,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [BBM_AW-1:0] reg_wdata,
    output logic [BBM_AW-1:0] reg_rdata,
    output logic              brk_req
);

    bus_cycle_t          cyc;
    cls_cycle_t          cls;
    ch_cfg_t [NUM_CH-1:0] cfg;
    logic [NUM_CH-1:0]   match;

    always_comb begin
        cyc.valid  = bus_valid;
        cyc.addr   = bus_addr;
        cyc.write  = bus_write;
        cyc.size   = bus_size_e'(bus_size);
        cyc.master = master_e'(bus_master);
        cyc.fetch  = bus_fetch;
    end

    bbm_classify u_classify (
        .clk   (clk),
        .rst   (rst),
        .cyc_i (cyc),
        .cls_o (cls)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        bbm_channel u_channel (
            .cfg_i   (cfg[c]),
            .cls_i   (cls),
            .match_o (match[c])
        );
    end

    bbm_regs #(
        .NUM_CH (NUM_CH),
        .RA_W   (RA_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .match_i   (match),
        .cfg_o     (cfg)
    );

    always_ff @(posedge clk) begin
        if (rst) brk_req <= 1'b0;
        else     brk_req <= (|match) && !cpu_block;
    end

    // R1: idle bus cycles produce no match
    a_r1_idle_no_match: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> (match == '0));

    // R8: every request follows an unblocked matching cycle
    a_r8_req_has_cause: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> $past(|match && !cpu_block));

    // R9: a blocked cycle is never followed by a request
    a_r9_block_suppresses: assert property (@(posedge clk) disable iff (rst)
        cpu_block |=> !brk_req);

    // R10: a matching unblocked cycle, single or double, yields a request
    a_r10_match_requests: assert property (@(posedge clk) disable iff (rst)
        ((|match) && !cpu_block) |=> brk_req);

endmodule

// File: tb/bus_break_monitor_tb.sv
module bus_break_monitor_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = 2'b00;
    logic [1:0]  bus_master = 2'b00;
    logic        bus_fetch = 1'b0;
    logic        cpu_block = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd3;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        brk_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_break_monitor u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_size(bus_size), .bus_master(bus_master),
        .bus_fetch(bus_fetch), .cpu_block(cpu_block), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .brk_req(brk_req)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_addr [2];
    logic [31:0] m_mask [2];
    logic [6:0]  m_ctrl [2];
    logic [1:0]  exp_flags = 2'b00;
    logic        exp_brk = 1'b0;

    function automatic bit model_hit(int ch);
        bit is_fetch;
        logic [1:0] k, d, s;
        if (!bus_valid) return 0;
        if (!m_ctrl[ch][0]) return 0;
        for (int b = 0; b < 32; b++)
            if (!m_mask[ch][b] && (bus_addr[b] != m_addr[ch][b])) return 0;
        is_fetch = (bus_master == 2'b00) && bus_fetch;
        k = m_ctrl[ch][2:1];
        d = m_ctrl[ch][4:3];
        s = m_ctrl[ch][6:5];
        if (k == 2'b01 && !is_fetch) return 0;
        if (k == 2'b10 && is_fetch) return 0;
        if (d == 2'b01 && bus_write) return 0;
        if (d == 2'b10 && !bus_write) return 0;
        if (s == 2'b01 && bus_size != 2'b00) return 0;
        if (s == 2'b10 && bus_size != 2'b01) return 0;
        if (s == 2'b11 && bus_size != 2'b10) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_flags = 2'b00;
            exp_brk   = 1'b0;
            for (int c = 0; c < 2; c++) begin
                m_addr[c] = '0; m_mask[c] = '0; m_ctrl[c] = '0;
            end
        end else begin
            logic [1:0] hits;
            hits[0] = model_hit(0);
            hits[1] = model_hit(1);
            exp_brk = (hits != 2'b00) && !cpu_block;
            if (reg_we && reg_addr == 3'd3) exp_flags = exp_flags & reg_wdata[1:0];
            exp_flags = exp_flags | hits;
            if (reg_we) begin
                case (reg_addr)
                    3'd0: m_addr[0] = reg_wdata;
                    3'd1: m_mask[0] = reg_wdata;
                    3'd2: m_ctrl[0] = reg_wdata[6:0];
                    3'd4: m_addr[1] = reg_wdata;
                    3'd5: m_mask[1] = reg_wdata;
                    3'd6: m_ctrl[1] = reg_wdata[6:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // every-clock comparison against the model (R8 request, R7 flags)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(brk_req == exp_brk, "R8 per-clock brk_req", 32'(brk_req), 32'(exp_brk));
            if (!reg_we && reg_addr == 3'd3)
                chk(reg_rdata[1:0] == exp_flags, "R7 per-clock flags",
                    reg_rdata, 32'(exp_flags));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd3; reg_wdata = '0;
    endtask

    task automatic reg_check(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
        reg_addr = 3'd3;
    endtask

    // drives one transfer; returns at the negedge after the sampling edge
    task automatic bus_cyc(input logic [31:0] a, input bit wr, input logic [1:0] sz,
                           input logic [1:0] mst, input bit fet);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_write = wr;
        bus_size = sz; bus_master = mst; bus_fetch = fet;
        @(negedge clk);
        bus_valid = 1'b0; bus_addr = '0; bus_write = 1'b0;
        bus_size = 2'b00; bus_master = 2'b00; bus_fetch = 1'b0;
    endtask

    task automatic expect_req(input bit exp, input string req);
        chk(brk_req == exp, req, 32'(brk_req), 32'(exp));
    endtask

    task automatic clear_flags();
        reg_write(3'd3, 32'h0);
    endtask

    // ---------------- sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        expect_req(1'b0, "R11 brk_req after reset");
        reg_check(3'd0, 32'h0, "R11 A address reset");
        reg_check(3'd2, 32'h0, "R11 A control reset");
        reg_check(3'd3, 32'h0, "R11 flags reset");
        reg_check(3'd6, 32'h0, "R11 B control reset");

        // R6: disabled channel with matching address stays silent
        reg_write(3'd0, 32'h0000_1000);
        bus_cyc(32'h0000_1000, 0, 2'b10, 2'b00, 0);
        expect_req(1'b0, "R6 disabled channel no request");
        reg_check(3'd3, 32'h0, "R6 disabled channel no flag");

        // R11 readback of registers; control keeps bits [6:0]
        reg_write(3'd2, 32'hFFFF_FF01);
        reg_check(3'd2, 32'h0000_007F & 32'hFFFF_FF01, "R11 A control readback");
        reg_check(3'd0, 32'h0000_1000, "R11 A address readback");
        reg_check(3'd7, 32'h0, "R11 register 7 reads zero");

        // R2 exact hit from CPU data read
        bus_cyc(32'h0000_1000, 0, 2'b10, 2'b00, 0);
        expect_req(1'b1, "R2 exact address hit request");
        @(negedge clk);
        expect_req(1'b0, "R8 request lasts one clock");
        reg_check(3'd3, 32'h1, "R7 flag A set");
        // R7 sticky, writing 1 keeps it
        reg_write(3'd3, 32'h3);
        reg_check(3'd3, 32'h1, "R7 writing 1 keeps flag");
        clear_flags();
        reg_check(3'd3, 32'h0, "R7 writing 0 clears flag");

        // R2 single bit miss, then masked hit; no rounding of aligned fetch
        bus_cyc(32'h0000_1004, 0, 2'b10, 2'b00, 0);
        expect_req(1'b0, "R2 single bit miss");
        reg_write(3'd0, 32'h0000_1002);
        bus_cyc(32'h0000_1000, 0, 2'b10, 2'b00, 1);
        expect_req(1'b0, "R2 aligned fetch vs unaligned break address");
        reg_write(3'd1, 32'h0000_0003);
        bus_cyc(32'h0000_1000, 0, 2'b10, 2'b00, 1);
        expect_req(1'b1, "R2 masked low bits hit");
        reg_write(3'd1, 32'h0);
        reg_write(3'd0, 32'h0000_1000);
        clear_flags();

        // R1 idle cycle with matching address is ignored
        @(negedge clk);
        bus_addr = 32'h0000_1000;
        @(negedge clk);
        bus_addr = '0;
        expect_req(1'b0, "R1 valid low not evaluated");
        reg_check(3'd3, 32'h0, "R1 valid low no flag");

        // R1/R3/R4: A matches fetch only
        reg_write(3'd2, 32'h0000_0003);
        bus_cyc(32'h0000_1000, 0, 2'b10, 2'b00, 1);
        expect_req(1'b1, "R4 fetch select hits CPU fetch");
        bus_cyc(32'h0000_1000, 0, 2'b10, 2'b01, 1);
        expect_req(1'b0, "R3 DMA0 with fetch bit is data");
        bus_cyc(32'h0000_1000, 0, 2'b10, 2'b00, 0);
        expect_req(1'b0, "R4 fetch select misses CPU data");
        // data only select
        reg_write(3'd2, 32'h0000_0005);
        bus_cyc(32'h0000_1000, 0, 2'b10, 2'b10, 1);
        expect_req(1'b1, "R3 DMA1 with fetch bit matches data select");
        bus_cyc(32'h0000_1000, 0, 2'b10, 2'b00, 1);
        expect_req(1'b0, "R4 data select misses CPU fetch");
        bus_cyc(32'h0000_1000, 1, 2'b00, 2'b01, 0);
        expect_req(1'b1, "R1 DMA0 cycle evaluated");
        clear_flags();

        // R5 direction: writes only, longword only
        reg_write(3'd2, 32'h0000_0071);
        bus_cyc(32'h0000_1000, 0, 2'b10, 2'b00, 0);
        expect_req(1'b0, "R5 write select misses read");
        bus_cyc(32'h0000_1000, 1, 2'b10, 2'b00, 0);
        expect_req(1'b1, "R5 write longword hits");
        bus_cyc(32'h0000_1000, 1, 2'b01, 2'b00, 0);
        expect_req(1'b0, "R5 longword select misses word");
        // byte, reads only
        reg_write(3'd2, 32'h0000_0029);
        bus_cyc(32'h0000_1000, 0, 2'b00, 2'b00, 0);
        expect_req(1'b1, "R5 byte read hits");
        bus_cyc(32'h0000_1000, 0, 2'b01, 2'b00, 0);
        expect_req(1'b0, "R5 byte select misses word");
        clear_flags();

        // R9 block bit: flag set, no request
        reg_write(3'd2, 32'h0000_0001);
        @(negedge clk);
        cpu_block = 1'b1;
        bus_cyc(32'h0000_1000, 0, 2'b10, 2'b00, 0);
        expect_req(1'b0, "R9 blocked no request");
        cpu_block = 1'b0;
        reg_check(3'd3, 32'h1, "R9 flag still set while blocked");
        clear_flags();

        // R10 both channels match a single cycle
        reg_write(3'd4, 32'h0000_2000);
        reg_write(3'd5, 32'h0000_F000);
        reg_write(3'd6, 32'h0000_0001);
        bus_cyc(32'h0000_1000, 0, 2'b10, 2'b00, 0);
        expect_req(1'b1, "R10 double match request");
        @(negedge clk);
        expect_req(1'b0, "R10 single pulse only");
        reg_check(3'd3, 32'h3, "R10 both flags set");
        // channel B alone
        reg_write(3'd3, 32'h1);
        reg_check(3'd3, 32'h1, "R7 clear B keep A");
        bus_cyc(32'h0000_2000, 0, 2'b10, 2'b00, 0);
        expect_req(1'b1, "R2 channel B alone hit");
        reg_check(3'd3, 32'h3, "R7 B flag set again");

        // R7 match and clearing write in the same cycle: flag stays
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h0;
        bus_valid = 1'b1; bus_addr = 32'h0000_2000; bus_write = 1'b0;
        bus_size = 2'b10; bus_master = 2'b00; bus_fetch = 1'b0;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd3; reg_wdata = '0; bus_valid = 1'b0; bus_addr = '0;
        reg_check(3'd3, 32'h2, "R7 set wins over clear");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule